// File: doc/BRIEF.md
# Privilege and Illegal-Instruction Trap Unit

This block sits after instruction decode and decides, for each instruction presented to it, whether the instruction may run or must be diverted into a program-check trap. There are two trap causes. The first is a supervisor-only operation attempted while the machine is in user (problem) state. The second is an encoding that the decoder has marked as illegal. When either cause applies, the unit works out the complete trap-entry state in one step. It produces the save-register values (the faulting address and the old machine state with a cause bit added), a new machine state word built from a fixed pattern, and the redirected next instruction address.

The unit has one registered stage. An instruction presented with `i_valid` high is judged at that clock edge, and the verdict and state values appear on the outputs in the following cycle, qualified by `o_valid`. When `o_trap_taken` is high, the surrounding pipeline uses it to drop the instruction's own results and to write the save registers and the machine state register. When it is low, the pipeline uses `o_nia` as the sequential successor and `o_msr` as the unchanged machine state. The machine state bit positions are parameters in big-endian (MSB0) numbering, so bit 0 is the most significant bit of the 64-bit word.

Top module: `priv_trap_unit`

## Requirements
- R1: Operation classes 1 (attention), 2 (read machine state), 3 (write machine state), 4 (write machine state, doubleword form) and 5 (return from interrupt) raise a privilege trap when the user-state bit (MSB0 bit 49 of `i_msr`) is 1.
- R2: Classes 6 (read special register) and 7 (write special register) are privileged only when bit 20 (LSB0) of `i_insn` is 1; with that bit at 0 they never raise a privilege trap.
- R3: When the user-state bit is 0, no operation class raises a privilege trap.
- R4: `i_illegal` high raises an illegal-instruction trap whatever the user-state bit is.
- R5: When a privilege trap and an illegal trap would both apply, only the privilege cause is reported; `o_trap_priv` and `o_trap_illeg` are never both high.
- R6: On a trap `o_nia` is 0x700; without a trap it is `i_cia` + 4, wrapping modulo 2^64.
- R7: On a trap `o_srr0` equals `i_cia`, and `o_srr1` equals `i_msr` with only the cause bit forced to 1 (MSB0 bit 45 for privilege, MSB0 bit 44 for illegal).
- R8: On a trap `o_msr` equals `i_msr` with MSB0 bits 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 60 and 62 cleared, MSB0 bits 0 and 63 set, and every other bit kept.
- R9: Without a trap `o_msr` equals `i_msr`, `o_srr0` and `o_srr1` are zero, and `o_trap_taken` is low.
- R10: Results appear one cycle after an `i_valid` cycle with `o_valid` high. Trap flags are low in any cycle without `o_valid`. In reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | An instruction is presented this cycle |
| i_op_class | input | 4 | Decoded operation class (0 none, 1–7 as in R1/R2, 8 ordinary) |
| i_insn | input | 32 | Raw instruction word |
| i_cia | input | 64 | Address of the presented instruction |
| i_msr | input | 64 | Current machine state word (MSB0 numbering) |
| i_illegal | input | 1 | Decoder marks the encoding illegal |
| o_valid | output | 1 | Outputs below carry a verdict |
| o_trap_taken | output | 1 | A trap was taken; suppress the instruction's results |
| o_trap_priv | output | 1 | Trap cause is privilege |
| o_trap_illeg | output | 1 | Trap cause is illegal encoding |
| o_nia | output | 64 | Next instruction address |
| o_srr0 | output | 64 | Saved address on trap, else zero |
| o_srr1 | output | 64 | Saved machine state with cause bit on trap, else zero |
| o_msr | output | 64 | New machine state word |

## Verification
The hardest case to reach is the collision of both causes. This is a privileged class in user state that the decoder also flags illegal, and the privilege cause must win while the save word carries only the privilege cause bit. The stimulus table sets up this case explicitly with a machine state word whose user bit is forced on, and it also includes the special-register classes with the selector bit toggled while every other instruction bit stays set. Directed cases add an all-ones and an all-zeros machine state word, which expose any cleared or set bit at the wrong position, and an address at the top of the space, which checks the sequential wrap.

// File: rtl/trap_pkg.sv
`timescale 1ns/1ps
package trap_pkg;
   localparam int OPC_W = 4;

   // decoded operation classes seen by the trap unit
   typedef enum logic [OPC_W-1:0] {
      OPC_NONE   = 4'd0,
      OPC_ATTN   = 4'd1,
      OPC_MFMSR  = 4'd2,
      OPC_MTMSR  = 4'd3,
      OPC_MTMSRD = 4'd4,
      OPC_RFID   = 4'd5,
      OPC_MFSPR  = 4'd6,
      OPC_MTSPR  = 4'd7,
      OPC_ALU    = 4'd8
   } op_class_e;
endpackage

// File: rtl/trap_detect.sv
`timescale 1ns/1ps
module trap_detect
   import trap_pkg::*;
#(
   parameter int INSN_W      = 32,
   parameter int SPR_SEL_BIT = 20
) (
   input  logic [OPC_W-1:0]  op_class,
   input  logic [INSN_W-1:0] insn,
   input  logic              user_mode,
   input  logic              illegal,
   output logic              priv_trap,
   output logic              illeg_trap
);
   if (SPR_SEL_BIT >= INSN_W || SPR_SEL_BIT < 0) begin : g_bad_sel
      $error("trap_detect: SPR_SEL_BIT outside instruction word");
   end

   op_class_e cls;
   logic      always_priv;
   logic      spr_class;
   logic      needs_priv;

   assign cls = op_class_e'(op_class);

   always_comb begin
      always_priv = 1'b0;
      spr_class   = 1'b0;
      case (cls)
         OPC_ATTN, OPC_MFMSR, OPC_MTMSR, OPC_MTMSRD, OPC_RFID: always_priv = 1'b1;
         OPC_MFSPR, OPC_MTSPR:                                  spr_class   = 1'b1;
         default: ;
      endcase
   end

   assign needs_priv = always_priv | (spr_class & insn[SPR_SEL_BIT]);
   // privilege cause outranks the illegal cause (R5)
   assign priv_trap  = needs_priv & user_mode;
   assign illeg_trap = illegal & ~priv_trap;
endmodule

// File: rtl/trap_state_calc.sv
`timescale 1ns/1ps
module trap_state_calc #(
   parameter int          XLEN     = 64,
   parameter int          NCLR     = 14,
   parameter int unsigned CLR_POS [NCLR] = '{31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 60, 62},
   parameter int          P_SF     = 0,
   parameter int          P_LE     = 63,
   parameter int          P_CPRIV  = 45,
   parameter int          P_CILLEG = 44
) (
   input  logic [XLEN-1:0] cur_msr,
   input  logic            priv_trap,
   input  logic            illeg_trap,
   output logic [XLEN-1:0] next_msr,
   output logic [XLEN-1:0] srr1_val
);
   localparam int L_SF     = XLEN - 1 - P_SF;
   localparam int L_LE     = XLEN - 1 - P_LE;
   localparam int L_CPRIV  = XLEN - 1 - P_CPRIV;
   localparam int L_CILLEG = XLEN - 1 - P_CILLEG;
   localparam logic [XLEN-1:0] SET_MASK = (XLEN'(1) << L_SF) | (XLEN'(1) << L_LE);
   localparam logic [XLEN-1:0] CPRIV_BIT = XLEN'(1) << L_CPRIV;
   localparam logic [XLEN-1:0] CILLEG_BIT = XLEN'(1) << L_CILLEG;

   logic [XLEN-1:0] clr_vec [NCLR];
   logic [XLEN-1:0] clr_mask;
   logic            trap;

   for (genvar k = 0; k < NCLR; k++) begin : g_clr
      if (CLR_POS[k] >= XLEN) begin : g_bad_pos
         $error("trap_state_calc: cleared position outside word");
      end
      assign clr_vec[k] = XLEN'(1) << (XLEN - 1 - int'(CLR_POS[k]));
   end

   always_comb begin
      clr_mask = '0;
      for (int k = 0; k < NCLR; k++) clr_mask = clr_mask | clr_vec[k];
   end

   assign trap = priv_trap | illeg_trap;

   always_comb begin
      if (trap) begin
         next_msr = (cur_msr & ~clr_mask) | SET_MASK;
         srr1_val = cur_msr | (priv_trap ? CPRIV_BIT : CILLEG_BIT);
      end else begin
         next_msr = cur_msr;
         srr1_val = '0;
      end
   end
endmodule

// File: rtl/priv_trap_unit.sv
`timescale 1ns/1ps
module priv_trap_unit #(
   parameter int              XLEN        = 64,
   parameter int              INSN_W      = 32,
   parameter int              SPR_SEL_BIT = 20,
   parameter longint unsigned TRAP_VEC    = 64'h700,
   parameter int              INSN_STRIDE = 4,
   parameter int              P_PR        = 49,
   parameter int              P_SF        = 0,
   parameter int              P_LE        = 63,
   parameter int              P_CPRIV     = 45,
   parameter int              P_CILLEG    = 44,
   parameter int              NCLR        = 14,
   parameter int unsigned     CLR_POS [NCLR] = '{31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 60, 62}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       i_valid,
   input  logic [trap_pkg::OPC_W-1:0] i_op_class,
   input  logic [INSN_W-1:0]          i_insn,
   input  logic [XLEN-1:0]            i_cia,
   input  logic [XLEN-1:0]            i_msr,
   input  logic                       i_illegal,
   output logic                       o_valid,
   output logic                       o_trap_taken,
   output logic                       o_trap_priv,
   output logic                       o_trap_illeg,
   output logic [XLEN-1:0]            o_nia,
   output logic [XLEN-1:0]            o_srr0,
   output logic [XLEN-1:0]            o_srr1,
   output logic [XLEN-1:0]            o_msr
);
   localparam int L_PR = XLEN - 1 - P_PR;
   localparam logic [XLEN-1:0] VEC_ADDR = XLEN'(TRAP_VEC);
   localparam logic [XLEN-1:0] STRIDE   = XLEN'(INSN_STRIDE);

   if (XLEN > 64 || XLEN < 8) begin : g_bad_xlen
      $error("priv_trap_unit: XLEN out of range");
   end
   if (P_PR >= XLEN || P_SF >= XLEN || P_LE >= XLEN ||
       P_CPRIV >= XLEN || P_CILLEG >= XLEN) begin : g_bad_pos
      $error("priv_trap_unit: machine state position outside word");
   end
   if (P_CPRIV == P_CILLEG) begin : g_same_cause
      $error("priv_trap_unit: cause bits must differ");
   end

   logic            det_priv;
   logic            det_illeg;
   logic [XLEN-1:0] calc_msr;
   logic [XLEN-1:0] calc_srr1;
   logic            det_trap;

   trap_detect #(
      .INSN_W     (INSN_W),
      .SPR_SEL_BIT(SPR_SEL_BIT)
   ) u_detect (
      .op_class  (i_op_class),
      .insn      (i_insn),
      .user_mode (i_msr[L_PR]),
      .illegal   (i_illegal),
      .priv_trap (det_priv),
      .illeg_trap(det_illeg)
   );

   trap_state_calc #(
      .XLEN    (XLEN),
      .NCLR    (NCLR),
      .CLR_POS (CLR_POS),
      .P_SF    (P_SF),
      .P_LE    (P_LE),
      .P_CPRIV (P_CPRIV),
      .P_CILLEG(P_CILLEG)
   ) u_state (
      .cur_msr   (i_msr),
      .priv_trap (det_priv),
      .illeg_trap(det_illeg),
      .next_msr  (calc_msr),
      .srr1_val  (calc_srr1)
   );

   assign det_trap = det_priv | det_illeg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid      <= 1'b0;
         o_trap_taken <= 1'b0;
         o_trap_priv  <= 1'b0;
         o_trap_illeg <= 1'b0;
         o_nia        <= '0;
         o_srr0       <= '0;
         o_srr1       <= '0;
         o_msr        <= '0;
      end else begin
         o_valid      <= i_valid;
         o_trap_taken <= i_valid & det_trap;
         o_trap_priv  <= i_valid & det_priv;
         o_trap_illeg <= i_valid & det_illeg;
         if (i_valid) begin
            o_nia  <= det_trap ? VEC_ADDR : i_cia + STRIDE;
            o_srr0 <= det_trap ? i_cia : '0;
            o_srr1 <= calc_srr1;
            o_msr  <= calc_msr;
         end
      end
   end
endmodule

// File: rtl/priv_trap_unit_chk.sv
`timescale 1ns/1ps
module priv_trap_unit_chk #(
   parameter int              XLEN        = 64,
   parameter longint unsigned TRAP_VEC    = 64'h700,
   parameter int              INSN_STRIDE = 4,
   parameter int              P_PR        = 49,
   parameter int              P_SF        = 0,
   parameter int              P_LE        = 63,
   parameter int              P_CPRIV     = 45,
   parameter int              P_CILLEG    = 44
) (
   input logic            clk,
   input logic            rst_n,
   input logic            i_valid,
   input logic [XLEN-1:0] i_cia,
   input logic [XLEN-1:0] i_msr,
   input logic            o_valid,
   input logic            o_trap_taken,
   input logic            o_trap_priv,
   input logic            o_trap_illeg,
   input logic [XLEN-1:0] o_nia,
   input logic [XLEN-1:0] o_srr0,
   input logic [XLEN-1:0] o_srr1,
   input logic [XLEN-1:0] o_msr
);
   localparam int L_PR     = XLEN - 1 - P_PR;
   localparam int L_SF     = XLEN - 1 - P_SF;
   localparam int L_LE     = XLEN - 1 - P_LE;
   localparam logic [XLEN-1:0] CPRIV  = XLEN'(1) << (XLEN - 1 - P_CPRIV);
   localparam logic [XLEN-1:0] CILLEG = XLEN'(1) << (XLEN - 1 - P_CILLEG);

   p_one_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({o_trap_priv, o_trap_illeg}));

   p_user_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      o_trap_priv |-> $past(i_msr[L_PR]));

   p_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_trap_taken) |-> (o_nia == XLEN'(TRAP_VEC)));

   p_seq_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_trap_taken) |-> (o_nia == $past(i_cia) + XLEN'(INSN_STRIDE)));

   p_save_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      o_trap_taken |-> (o_srr0 == $past(i_cia)));

   p_save_priv_r7: assert property (@(posedge clk) disable iff (!rst_n)
      o_trap_priv |-> (o_srr1 == ($past(i_msr) | CPRIV)));

   p_save_illeg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      o_trap_illeg |-> (o_srr1 == ($past(i_msr) | CILLEG)));

   p_new_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      o_trap_taken |-> (o_msr[L_SF] && o_msr[L_LE] && !o_msr[L_PR]));

   p_keep_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_trap_taken) |-> (o_msr == $past(i_msr) && o_srr0 == '0 && o_srr1 == '0));

   p_trap_qual_r10: assert property (@(posedge clk) disable iff (!rst_n)
      o_trap_taken |-> o_valid);

   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(o_valid) |-> $past(i_valid));
endmodule

bind priv_trap_unit priv_trap_unit_chk #(
   .XLEN       (XLEN),
   .TRAP_VEC   (TRAP_VEC),
   .INSN_STRIDE(INSN_STRIDE),
   .P_PR       (P_PR),
   .P_SF       (P_SF),
   .P_LE       (P_LE),
   .P_CPRIV    (P_CPRIV),
   .P_CILLEG   (P_CILLEG)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .i_valid     (i_valid),
   .i_cia       (i_cia),
   .i_msr       (i_msr),
   .o_valid     (o_valid),
   .o_trap_taken(o_trap_taken),
   .o_trap_priv (o_trap_priv),
   .o_trap_illeg(o_trap_illeg),
   .o_nia       (o_nia),
   .o_srr0      (o_srr0),
   .o_srr1      (o_srr1),
   .o_msr       (o_msr)
);

// File: tb/test_priv_trap_unit.sv
`timescale 1ns/1ps
module test_priv_trap_unit;
   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] insn;
      logic        pr;
      logic        ill;
      logic        e_priv;
      logic        e_ill;
      logic [2:0]  rq;
   } vec_t;

   localparam logic [31:0] W_SEL1 = 32'h7C1F_FFFF; // bit 20 set
   localparam logic [31:0] W_SEL0 = 32'h7C0F_FFFF; // bit 20 clear
   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{4'd1, W_SEL0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1},
      '{4'd2, W_SEL0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1},
      '{4'd3, W_SEL0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1},
      '{4'd4, W_SEL0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1},
      '{4'd5, W_SEL0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd1},
      '{4'd5, W_SEL1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
      '{4'd6, W_SEL1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd2},
      '{4'd6, W_SEL0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2},
      '{4'd7, W_SEL1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd2},
      '{4'd7, W_SEL1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
      '{4'd8, W_SEL1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},
      '{4'd8, W_SEL0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4},
      '{4'd8, W_SEL0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4},
      '{4'd3, W_SEL0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd5},
      '{4'd7, W_SEL0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2},
      '{4'd1, W_SEL1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4}
   };

   // MSB0 positions from the requirements
   localparam int PR_B   = 63 - 49;
   localparam int CPRIV  = 63 - 45;
   localparam int CILL   = 63 - 44;
   localparam int NCL    = 14;
   localparam int CL_MSB0 [NCL] = '{31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 60, 62};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_valid = 1'b0;
   logic [3:0]  i_op_class = '0;
   logic [31:0] i_insn = '0;
   logic [63:0] i_cia = '0;
   logic [63:0] i_msr = '0;
   logic        i_illegal = 1'b0;
   logic        o_valid, o_trap_taken, o_trap_priv, o_trap_illeg;
   logic [63:0] o_nia, o_srr0, o_srr1, o_msr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   priv_trap_unit i_priv_trap_unit (
      .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_op_class(i_op_class),
      .i_insn(i_insn), .i_cia(i_cia), .i_msr(i_msr), .i_illegal(i_illegal),
      .o_valid(o_valid), .o_trap_taken(o_trap_taken), .o_trap_priv(o_trap_priv),
      .o_trap_illeg(o_trap_illeg), .o_nia(o_nia), .o_srr0(o_srr0),
      .o_srr1(o_srr1), .o_msr(o_msr)
   );

   function automatic logic [63:0] clr_mask();
      logic [63:0] m = '0;
      for (int k = 0; k < NCL; k++) m[63 - CL_MSB0[k]] = 1'b1;
      return m;
   endfunction

   function automatic logic [63:0] trap_msr(logic [63:0] m);
      logic [63:0] r = m & ~clr_mask();
      r[63] = 1'b1; // MSB0 bit 0
      r[0]  = 1'b1; // MSB0 bit 63
      return r;
   endfunction

   function automatic string rq_name(logic [2:0] r);
      case (r)
         3'd1: return "R1";
         3'd2: return "R2";
         3'd3: return "R3";
         3'd4: return "R4";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // present one instruction, then sample the registered result
   task automatic apply(logic [3:0] op, logic [31:0] insn, logic [63:0] cia,
                        logic [63:0] msr, logic ill);
      @(negedge clk);
      i_valid = 1'b1; i_op_class = op; i_insn = insn;
      i_cia = cia; i_msr = msr; i_illegal = ill;
      @(negedge clk);
      i_valid = 1'b0; i_illegal = 1'b0; i_op_class = '0;
   endtask

   task automatic expect_all(string req, logic [63:0] cia, logic [63:0] msr,
                             logic e_priv, logic e_ill);
      logic tr = e_priv | e_ill;
      logic [63:0] e_srr1 = '0;
      if (tr) begin
         e_srr1 = msr;
         e_srr1[e_priv ? CPRIV : CILL] = 1'b1;
      end
      chk(req, "flags", {60'd0, o_valid, o_trap_taken, o_trap_priv, o_trap_illeg},
          {60'd0, 1'b1, tr, e_priv, e_ill});
      chk(req, "nia",  o_nia,  tr ? 64'h700 : cia + 64'd4);
      chk(req, "srr0", o_srr0, tr ? cia : 64'd0);
      chk(req, "srr1", o_srr1, e_srr1);
      chk(req, "msr",  o_msr,  tr ? trap_msr(msr) : msr);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      #12;
      chk("R10", "reset flags", {60'd0, o_valid, o_trap_taken, o_trap_priv, o_trap_illeg}, 64'd0);
      chk("R10", "reset nia", o_nia, 64'd0);
      chk("R10", "reset state", o_srr0 | o_srr1 | o_msr, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic [63:0] msr = 64'hA5C3_3C5A_0FF0_9669 ^ {32'd0, 32'(v) * 32'h0101_0101};
         logic [63:0] cia = 64'h0000_0000_0001_0000 + 64'(v) * 64'h40;
         msr[PR_B] = VECS[v].pr;
         apply(VECS[v].op, VECS[v].insn, cia, msr, VECS[v].ill);
         expect_all(rq_name(VECS[v].rq), cia, msr, VECS[v].e_priv, VECS[v].e_ill);
      end

      // R8: all-ones state word under privilege trap
      apply(4'd2, W_SEL0, 64'h0000_0000_0000_2000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      expect_all("R8", 64'h0000_0000_0000_2000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);

      // R8: all-zero state word under illegal trap
      apply(4'd8, 32'h0, 64'h0000_0000_0000_3004, 64'd0, 1'b1);
      expect_all("R8", 64'h0000_0000_0000_3004, 64'd0, 1'b0, 1'b1);
      chk("R8", "zero-msr pattern", o_msr, 64'h8000_0000_0000_0001);

      // R6: sequential address wraps at the top of the space
      apply(4'd8, 32'h0, 64'hFFFF_FFFF_FFFF_FFFC, 64'd0, 1'b0);
      expect_all("R6", 64'hFFFF_FFFF_FFFF_FFFC, 64'd0, 1'b0, 1'b0);

      // R9: class 0 in user state, no trap, state unchanged
      apply(4'd0, W_SEL1, 64'h40, 64'h0002_0000_0000_4000, 1'b0);
      expect_all("R9", 64'h40, 64'h0002_0000_0000_4000, 1'b0, 1'b0);

      // R10: idle cycle after a verdict drops valid and trap flags
      apply(4'd1, W_SEL0, 64'h80, 64'h0000_0000_0000_4000, 1'b0);
      @(negedge clk);
      chk("R10", "idle flags", {60'd0, o_valid, o_trap_taken, o_trap_priv, o_trap_illeg}, 64'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule